// File: doc/BRIEF.md
# MSI Event Queue Controller

This block takes inbound message-signalled-interrupt posted writes, each made of a write address offset and a 32-bit data word. It decodes a queue number from the offset and appends the data word, unchanged, to that queue's ring in system memory. The ring write goes out through a fire-and-forget memory write port. The block keeps up to six rings, and each ring has 64 slots of 32 bits.

The tail pointer belongs to the hardware. It moves forward only after the memory write for that slot has already been presented, so software never sees a tail that covers an entry not yet written. Software drains entries from head up to, but not including, tail, and then writes a new head through the register port. Each queue drives a level interrupt that stays high while the queue holds unconsumed entries and its enables are set.

The layout is chosen by a parameter. In shared mode, every ring sits behind the page base of queue 0, with queue n at byte offset n·256, and the inbound offset n·4 selects queue n. In per-region mode, each queue has its own 4 KiB page base, and the inbound offset n·4096 selects queue n.

Top module: `msi_eq_ctrl`

## Requirements
- R1: After reset, all control bits, head and tail pointers, overflow flags, interrupt outputs and mem_we are zero.
- R2: In shared mode, a write offset of exactly n·4 with n < NQ routes to queue n. An offset whose two low bits are not zero, or whose quotient is NQ or more, writes nothing.
- R3: In shared mode, an accepted entry is written to (base of queue 0) + n·256 + slot·4, where base = {base_hi, base_lo}. The data word is written unmodified. mem_we, mem_addr and mem_wdata are valid in the cycle after the inbound write.
- R4: Each accepted entry advances that queue's tail by one, modulo 64, one cycle after its memory write appears. A tail of 63 wraps to 0. Writes to the same queue on back-to-back cycles go to consecutive slots.
- R5: An inbound write to a queue whose enable bit (control bit 0) is clear produces no memory write and leaves that queue's tail unchanged.
- R6: When (tail + 1) mod 64 equals head, the ring is full. A write to a full ring is dropped and sets that queue's sticky overflow output, which stays set until reset.
- R7: irq[n] is high exactly when control bits 0, 1 and 11 of queue n are all set and head differs from tail.
- R8: A head write that makes head equal to tail drops irq[n] in the cycle right after the write.
- R9: Register map, with reg_addr[5:3] as the queue and reg_addr[2:0] as the field: 0 control, 1 head, 2 tail, 3 base low 32 bits, 4 base high 32 bits. Control reads back only bits 0, 1 and 11. Head keeps 6 bits. Writes to tail are ignored.
- R10: In per-region mode (PER_REGION=1), the offset bits [AW-1:12] select the queue and the low 12 bits are ignored. The entry is written to (base of queue n) + slot·4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound posted write present |
| in_addr | input | AW | Inbound write address offset |
| in_data | input | 32 | Inbound data word |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | clog2(NQ)+3 | Register select: queue and field |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_we | output | 1 | Ring memory write strobe |
| mem_addr | output | 64 | Ring memory byte address |
| mem_wdata | output | 32 | Ring memory write data |
| irq | output | NQ | Per-queue level interrupt |
| ovf | output | NQ | Per-queue sticky overflow flag |

## Verification
A table of inbound writes covers several kinds of offset:
- aligned offsets for different queues, each checked against its own computed ring address;
- a repeated queue, which separates per-queue slot counting from a single shared counter;
- a disabled queue, an out-of-range offset and a misaligned offset, each of which must produce no write.

Back-to-back writes to one queue show whether an entry that is still in flight is counted before the second slot is chosen.

Filling a ring to 63 entries checks the full boundary and the overflow flag. One more write after head advances checks that the tail wraps from 63 to 0.

A second instance in per-region mode uses a page-selected offset with non-zero low bits, which separates that mode's routing and addressing from shared mode.

// File: rtl/msi_eq_pkg.sv
package msi_eq_pkg;
  localparam int PTR_W   = 6;
  localparam int CB_EN   = 0;
  localparam int CB_EVT  = 1;
  localparam int CB_INT  = 11;
  localparam int QSTRIDE = 256;

  typedef enum logic [2:0] {
    F_CTRL    = 3'd0,
    F_HEAD    = 3'd1,
    F_TAIL    = 3'd2,
    F_BASE_LO = 3'd3,
    F_BASE_HI = 3'd4
  } field_e;

  function automatic logic ring_full(logic [PTR_W-1:0] t, logic [PTR_W-1:0] h);
    return (t + PTR_W'(1)) == h;
  endfunction

  function automatic logic [PTR_W-1:0] pending(logic [PTR_W-1:0] t, logic [PTR_W-1:0] h);
    return t - h;
  endfunction

  function automatic logic [63:0] entry_addr(logic [63:0] base, logic [7:0] q,
                                             logic [PTR_W-1:0] slot, bit per_region);
    logic [63:0] qoff;
    qoff = per_region ? 64'd0 : 64'(q) * 64'(QSTRIDE);
    return base + qoff + {{(62-PTR_W){1'b0}}, slot, 2'b00};
  endfunction
endpackage

// File: rtl/msi_eq_router.sv
module msi_eq_router #(
  parameter int NQ         = 6,
  parameter int AW         = 16,
  parameter bit PER_REGION = 1'b0
) (
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  output logic [NQ-1:0] push
);
  localparam int SHIFT = PER_REGION ? 12 : 2;

  logic [AW-1:0] grp;
  logic          hit;

  assign grp = in_addr >> SHIFT;
  assign hit = (grp < AW'(NQ)) && (PER_REGION || (in_addr[1:0] == 2'b00));

  for (genvar i = 0; i < NQ; i++) begin : g_sel
    assign push[i] = in_valid && hit && (grp == AW'(i));
  end
endmodule

// File: rtl/msi_eq_queue.sv
module msi_eq_queue
  import msi_eq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_field,
  input  logic [31:0]      wr_data,
  input  logic             push,
  output logic             accept,
  output logic [PTR_W-1:0] slot,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [31:0]      ctrl_rd,
  output logic [63:0]      base,
  output logic             ovf,
  output logic             irq,
  output logic             tail_adv
);
  logic en, evt, ien, commit_q, full;

  assign slot     = tail + PTR_W'(commit_q);
  assign full     = ring_full(slot, head);
  assign accept   = push && en && !full;
  assign tail_adv = commit_q;
  assign ctrl_rd  = {20'd0, ien, 9'd0, evt, en};
  assign irq      = en && evt && ien && (pending(tail, head) != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; evt <= 1'b0; ien <= 1'b0;
      head <= '0; tail <= '0; base <= '0;
      ovf <= 1'b0; commit_q <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_field)
          F_CTRL: begin
            en  <= wr_data[CB_EN];
            evt <= wr_data[CB_EVT];
            ien <= wr_data[CB_INT];
          end
          F_HEAD:    head <= wr_data[PTR_W-1:0];
          F_BASE_LO: base[31:0] <= wr_data;
          F_BASE_HI: base[63:32] <= wr_data;
          default: ;
        endcase
      end
      commit_q <= accept;
      if (commit_q) tail <= tail + PTR_W'(1);
      if (push && en && full) ovf <= 1'b1;
    end
  end

  a_r4_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tail != $past(tail)) |-> (tail == $past(tail) + PTR_W'(1)));
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  a_r5_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !commit_q) |=> $stable(tail));
  a_r7_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (head == tail) |-> !irq);
endmodule

// File: rtl/msi_eq_ctrl.sv
module msi_eq_ctrl
  import msi_eq_pkg::*;
#(
  parameter int NQ         = 6,
  parameter int AW         = 16,
  parameter bit PER_REGION = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [AW-1:0]          in_addr,
  input  logic [31:0]            in_data,
  input  logic                   reg_we,
  input  logic [$clog2(NQ)+2:0]  reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  output logic                   mem_we,
  output logic [63:0]            mem_addr,
  output logic [31:0]            mem_wdata,
  output logic [NQ-1:0]          irq,
  output logic [NQ-1:0]          ovf
);
  localparam int QW = $clog2(NQ);

  logic [NQ-1:0]    push, accept, tail_adv;
  logic [PTR_W-1:0] slot_a [NQ];
  logic [PTR_W-1:0] head_a [NQ];
  logic [PTR_W-1:0] tail_a [NQ];
  logic [31:0]      ctrl_a [NQ];
  logic [63:0]      base_a [NQ];
  logic [QW-1:0]    rq;
  logic [2:0]       rf;
  logic             any_acc;
  logic [63:0]      next_addr;

  assign rq = reg_addr[QW+2:3];
  assign rf = reg_addr[2:0];

  msi_eq_router #(.NQ(NQ), .AW(AW), .PER_REGION(PER_REGION)) u_route (
    .in_valid(in_valid), .in_addr(in_addr), .push(push));

  for (genvar i = 0; i < NQ; i++) begin : g_q
    msi_eq_queue u_q (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_we && (rq == QW'(i))), .wr_field(rf), .wr_data(reg_wdata),
      .push(push[i]), .accept(accept[i]), .slot(slot_a[i]),
      .head(head_a[i]), .tail(tail_a[i]), .ctrl_rd(ctrl_a[i]),
      .base(base_a[i]), .ovf(ovf[i]), .irq(irq[i]), .tail_adv(tail_adv[i]));

    a_r4_commit_first: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_a[i] != $past(tail_a[i])) |-> $past(mem_we));
  end

  always_comb begin
    any_acc   = 1'b0;
    next_addr = '0;
    for (int i = 0; i < NQ; i++) begin
      if (accept[i]) begin
        any_acc   = 1'b1;
        next_addr = entry_addr(PER_REGION ? base_a[i] : base_a[0], 8'(i), slot_a[i], PER_REGION);
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NQ; i++) begin
      if (rq == QW'(i)) begin
        case (rf)
          F_CTRL:    reg_rdata = ctrl_a[i];
          F_HEAD:    reg_rdata = 32'(head_a[i]);
          F_TAIL:    reg_rdata = 32'(tail_a[i]);
          F_BASE_LO: reg_rdata = base_a[i][31:0];
          F_BASE_HI: reg_rdata = base_a[i][63:32];
          default:   reg_rdata = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= any_acc;
      if (any_acc) begin
        mem_addr  <= next_addr;
        mem_wdata <= in_data;
      end
    end
  end

  a_r2_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(accept));
  a_r4_adv_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|tail_adv) |-> mem_we);
endmodule

// File: tb/msi_eq_ctrl_test.sv
module msi_eq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] a;
    logic [31:0] d;
    logic        we;
    logic [63:0] ma;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{16'h0000, 32'h0000_0020, 1'b1, 64'h0000_0002_1000_0000},
    '{16'h0004, 32'h0000_0041, 1'b1, 64'h0000_0002_1000_0100},
    '{16'h0000, 32'h0000_0040, 1'b1, 64'h0000_0002_1000_0004},
    '{16'h000C, 32'h0000_007F, 1'b1, 64'h0000_0002_1000_0300},
    '{16'h0010, 32'h0000_0099, 1'b0, 64'h0},
    '{16'h0018, 32'h0000_00AA, 1'b0, 64'h0},
    '{16'h0002, 32'h0000_00BB, 1'b0, 64'h0},
    '{16'h0014, 32'h0000_00E0, 1'b1, 64'h0000_0002_1000_0500}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic vs = 1'b0, vp = 1'b0, ws = 1'b0, wp = 1'b0;
  logic [15:0] in_addr = '0;
  logic [31:0] in_data = '0, reg_wdata = '0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] rd_s, rd_p, wd_s, wd_p;
  logic [63:0] ma_s, ma_p;
  logic        we_s, we_p;
  logic [5:0]  irq_s, irq_p, ovf_s, ovf_p;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_eq_ctrl #(.NQ(6), .AW(16), .PER_REGION(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(vs), .in_addr(in_addr), .in_data(in_data),
    .reg_we(ws), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_s),
    .mem_we(we_s), .mem_addr(ma_s), .mem_wdata(wd_s), .irq(irq_s), .ovf(ovf_s));

  msi_eq_ctrl #(.NQ(6), .AW(16), .PER_REGION(1'b1)) uut_pr (
    .clk(clk), .rst_n(rst_n), .in_valid(vp), .in_addr(in_addr), .in_data(in_data),
    .reg_we(wp), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_p),
    .mem_we(we_p), .mem_addr(ma_p), .mem_wdata(wd_p), .irq(irq_p), .ovf(ovf_p));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(bit pr, int q, int f, logic [31:0] v);
    @(negedge clk);
    reg_addr = 6'((q << 3) | f); reg_wdata = v;
    if (pr) wp = 1'b1; else ws = 1'b1;
    @(negedge clk);
    ws = 1'b0; wp = 1'b0;
  endtask

  task automatic rreg(bit pr, int q, int f, output logic [31:0] v);
    reg_addr = 6'((q << 3) | f);
    #1;
    v = pr ? rd_p : rd_s;
  endtask

  task automatic send(bit pr, logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    in_addr = a; in_data = d;
    if (pr) vp = 1'b1; else vs = 1'b1;
    @(negedge clk);
    vs = 1'b0; vp = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rreg(0, 0, 0, r); chk("R1 ctrl", r, 0);
    rreg(0, 3, 1, r); chk("R1 head", r, 0);
    rreg(0, 5, 2, r); chk("R1 tail", r, 0);
    chk("R1 irq", irq_s, 0); chk("R1 ovf", ovf_s, 0); chk("R1 mem_we", we_s, 0);

    wreg(0, 0, 3, 32'h1000_0000);
    wreg(0, 0, 4, 32'h0000_0002);
    wreg(0, 0, 0, 32'h803); wreg(0, 1, 0, 32'h803);
    wreg(0, 2, 0, 32'h003); wreg(0, 3, 0, 32'h803);
    wreg(0, 5, 0, 32'h803);

    // R2 R3 table of inbound writes (shared mode)
    foreach (VECS[i]) begin
      send(0, VECS[i].a, VECS[i].d);
      chk("R2 mem_we", we_s, VECS[i].we);
      if (VECS[i].we) begin
        chk("R3 mem_addr", ma_s, VECS[i].ma);
        chk("R3 mem_wdata", wd_s, VECS[i].d);
      end
    end
    @(negedge clk);
    rreg(0, 0, 2, r); chk("R4 tail q0", r, 2);
    rreg(0, 1, 2, r); chk("R4 tail q1", r, 1);
    rreg(0, 3, 2, r); chk("R4 tail q3", r, 1);
    rreg(0, 4, 2, r); chk("R5 tail q4 disabled", r, 0);
    chk("R7 irq pattern", irq_s, 6'b101011);

    // R4 back-to-back to q2
    @(negedge clk);
    in_addr = 16'h0008; in_data = 32'hA0; vs = 1'b1;
    @(negedge clk);
    chk("R4 b2b first addr", ma_s, 64'h0000_0002_1000_0200);
    in_data = 32'hB0;
    @(negedge clk);
    vs = 1'b0;
    chk("R4 b2b second addr", ma_s, 64'h0000_0002_1000_0204);
    chk("R4 b2b second data", wd_s, 32'hB0);
    @(negedge clk);
    rreg(0, 2, 2, r); chk("R4 b2b tail q2", r, 2);
    chk("R7 irq off without bit11", irq_s[2], 0);
    wreg(0, 2, 0, 32'h803);
    chk("R7 irq on with all bits", irq_s[2], 1);

    // R8 head catch-up
    @(negedge clk);
    reg_addr = 6'((0 << 3) | 1); reg_wdata = 2; ws = 1'b1;
    @(negedge clk);
    ws = 1'b0;
    chk("R8 irq drop", irq_s[0], 0);

    // R6 fill q1 to full
    for (int k = 0; k < 62; k++) send(0, 16'h0004, 32'(k));
    @(negedge clk);
    rreg(0, 1, 2, r); chk("R6 tail at 63", r, 63);
    chk("R6 ovf before", ovf_s[1], 0);
    send(0, 16'h0004, 32'hDEAD);
    chk("R6 full drop", we_s, 0);
    @(negedge clk);
    chk("R6 ovf set", ovf_s[1], 1);
    rreg(0, 1, 2, r); chk("R6 tail held", r, 63);
    wreg(0, 1, 1, 5);
    send(0, 16'h0004, 32'h1234);
    chk("R4 slot63 addr", ma_s, 64'h0000_0002_1000_01FC);
    @(negedge clk);
    rreg(0, 1, 2, r); chk("R4 wrap to 0", r, 0);
    chk("R6 ovf sticky", ovf_s[1], 1);

    // R9 register bank
    wreg(0, 4, 0, 32'hFFFF_FFFF);
    rreg(0, 4, 0, r); chk("R9 ctrl mask", r, 32'h803);
    wreg(0, 4, 0, 0);
    wreg(0, 3, 1, 32'hFF);
    rreg(0, 3, 1, r); chk("R9 head width", r, 32'h3F);
    wreg(0, 3, 1, 1);
    wreg(0, 0, 2, 9);
    rreg(0, 0, 2, r); chk("R9 tail write ignored", r, 2);
    rreg(0, 0, 4, r); chk("R9 base hi", r, 2);

    // R10 per-region instance
    wreg(1, 2, 3, 32'h0000_3000);
    wreg(1, 2, 0, 32'h803);
    send(1, 16'h207C, 32'h55);
    chk("R10 addr slot0", ma_p, 64'h3000);
    chk("R10 data", wd_p, 32'h55);
    send(1, 16'h2000, 32'h56);
    chk("R10 addr slot1", ma_p, 64'h3004);
    send(1, 16'h0008, 32'h57);
    chk("R10 page0 disabled drop", we_p, 0);
    @(negedge clk);
    chk("R10 irq", irq_p, 6'b000100);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule